// File: doc/BRIEF.md
# RTC Update Cycle and Alarm Controller

This block runs the once-per-second update of a real-time clock. A one-second tick starts an update, but only while the oscillator-control field of control register A selects normal running. When the update starts, the block pulses the time counters so that they advance, and it raises the update-in-progress status bit. A fixed number of time-base ticks later the block completes the update. At completion it pulses a publish strobe that copies the new time into the user-visible registers. It also compares the alarm bytes with the current seconds, minutes and hours, and raises the update-ended and alarm flags in register C. Any flag raised through an enabled source drives the interrupt line.

Software reaches control registers A, B, C and D through a small register port. That port enforces the special write rules. The update-in-progress bit cannot be written. Setting the SET bit freezes the visible time and disables the update-ended interrupt. Clearing the SET bit asks the counters to reload the time from the registers. Reading register C clears its flags.

Top module: `rtc_update_ctrl`

## Requirements
- R1: After reset, register A reads 0x26, register B reads 0x00, register C reads 0x00, register D reads 0x80, and irq is low. The reg_sel codes are 0 for A, 1 for B, 2 for C and 3 for D.
- R2: An update starts on a sec_tick cycle only when A[6:4] equals 3'b010 and no update is running. adv_time pulses in that same cycle. A tick under any other A[6:4] value is ignored: no adv_time, no status change, no publish.
- R3: The update-in-progress bit A[7] is set when an update starts, but only if B[7] (SET) is clear. It is cleared when the update completes.
- R4: The update completes in the cycle of the UPD_TICKS-th tb_en tick after the start cycle. publish pulses in that cycle unless SET is high.
- R5: A[7] is read-only. A write to A changes only A[6:0].
- R6: A write to B with bit 7 high clears A[7] at once and stores B[4] as 0.
- R7: A write to B with bit 7 low, while the stored B[7] is 1, pulses reload for one cycle, in the write cycle. A write that leaves SET low does not pulse reload.
- R8: When B[5] is set, completion sets C[7] and C[5] if each of the seconds, minutes and hours alarm bytes either equals the current byte or has bits 7:6 equal to 2'b11.
- R9: When B[4] is set, completion sets C[7] and C[4]. irq follows C[7].
- R10: A read of C returns the flags and clears them, which drops irq. A flag set in the same cycle as the read is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | One-cycle enable per 32.768 kHz time-base tick |
| sec_tick | input | 1 | One-second tick |
| reg_sel | input | 2 | Register select: 0 A, 1 B, 2 C, 3 D |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears C when it is selected) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| adv_time | output | 1 | Pulse that tells the counters to advance one second |
| publish | output | 1 | Pulse that copies the new time into the visible registers |
| reload | output | 1 | Pulse that reloads the counters from the registers |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the properties that can be judged one cycle at a time, on every cycle. The status bit may be high only while an update is running. The update counter stays inside its window. A write with SET high always leaves the update-ended enable low. A write to A never moves the status bit. A read of C with no new event leaves C empty. The bench scenarios cover what needs a full sequence. These are the exact tick count from start to publish at two time-base rates, and a tick that the oscillator field blocks. They also include the reload pulse when SET goes from high to low, and the wildcard alarm matches. A last scenario shows that a flag raised in the same cycle as a read of C survives that read.

// File: rtl/rtcu_pkg.sv
package rtcu_pkg;
  typedef enum logic [1:0] {
    SEL_A = 2'd0,
    SEL_B = 2'd1,
    SEL_C = 2'd2,
    SEL_D = 2'd3
  } rtcu_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } rtcu_state_e;

  localparam logic [7:0] A_RESET   = 8'h26;
  localparam logic [7:0] B_RESET   = 8'h00;
  localparam logic [7:0] C_RESET   = 8'h00;
  localparam logic [7:0] D_VALUE   = 8'h80;
  localparam logic [2:0] OSC_RUN   = 3'b010;
  localparam logic [1:0] WILDCARD  = 2'b11;
  localparam logic [7:0] FLAG_UPD  = 8'h90;
  localparam logic [7:0] FLAG_ALM  = 8'hA0;
  localparam logic [7:0] UIE_CLEAR = 8'hEF;
  localparam int         BIT_UIP   = 7;
  localparam int         BIT_SET   = 7;
  localparam int         BIT_AIE   = 5;
  localparam int         BIT_UIE   = 4;
endpackage

// File: rtl/rtcu_rst_sync.sv
module rtcu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rtcu_ctrl_regs.sv
module rtcu_ctrl_regs
  import rtcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic [7:0] wdata,
  input  logic       uip_set,
  input  logic       uip_done_clr,
  output logic [7:0] reg_a,
  output logic [7:0] reg_b,
  output logic       reload
);
  logic [7:0] a_q, a_nxt;
  logic [7:0] b_q, b_nxt;

  always_comb begin
    a_nxt  = a_q;
    b_nxt  = b_q;
    reload = 1'b0;
    if (uip_set)      a_nxt[BIT_UIP] = 1'b1;
    if (uip_done_clr) a_nxt[BIT_UIP] = 1'b0;
    if (wr_a)         a_nxt[6:0]     = wdata[6:0];
    if (wr_b) begin
      if (wdata[BIT_SET]) begin
        a_nxt[BIT_UIP] = 1'b0;
        b_nxt          = wdata & UIE_CLEAR;
      end else begin
        b_nxt  = wdata;
        reload = b_q[BIT_SET];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= A_RESET;
      b_q <= B_RESET;
    end else begin
      a_q <= a_nxt;
      b_q <= b_nxt;
    end
  end

  assign reg_a = a_q;
  assign reg_b = b_q;

  AST_SET_KILLS_UIE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && wdata[BIT_SET]) |=> (!b_q[BIT_UIE] && !a_q[BIT_UIP])); // R6

  AST_UIP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !wr_b && !uip_set && !uip_done_clr) |=> (a_q[BIT_UIP] == $past(a_q[BIT_UIP]))); // R5
endmodule

// File: rtl/rtcu_update_seq.sv
module rtcu_update_seq
  import rtcu_pkg::*;
#(
  parameter int UPD_TICKS = 32440
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tb_en,
  input  logic sec_tick,
  input  logic osc_ok,
  output logic start,
  output logic done,
  output logic busy
);
  localparam int CW = $clog2(UPD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(UPD_TICKS - 1);

  rtcu_state_e state_q, state_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;

  assign busy  = (state_q == ST_BUSY);
  assign start = !busy && sec_tick && osc_ok;
  assign done  = busy && tb_en && (cnt_q == LAST);

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    if (start) begin
      state_nxt = ST_BUSY;
      cnt_nxt   = '0;
    end else if (done) begin
      state_nxt = ST_IDLE;
      cnt_nxt   = '0;
    end else if (busy && tb_en) begin
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nxt;
      cnt_q   <= cnt_nxt;
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= LAST)); // R4

  AST_START_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sec_tick && osc_ok)); // R2
endmodule

// File: rtl/rtcu_alarm_cmp.sv
module rtcu_alarm_cmp
  import rtcu_pkg::*;
#(
  parameter int NUM_FIELDS = 3,
  parameter int FW = 8
) (
  input  logic [NUM_FIELDS-1:0][FW-1:0] alarm_bytes,
  input  logic [NUM_FIELDS-1:0][FW-1:0] now_bytes,
  output logic                          hit
);
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign field_ok[i] = (alarm_bytes[i][FW-1:FW-2] == WILDCARD) ||
                         (alarm_bytes[i] == now_bytes[i]);
  end

  assign hit = &field_ok;
endmodule

// File: rtl/rtcu_flags.sv
module rtcu_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set_mask,
  input  logic       rd_clr,
  output logic [7:0] flags
);
  logic [7:0] c_q, c_nxt;

  always_comb begin
    c_nxt = (rd_clr ? 8'h00 : c_q) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= rtcu_pkg::C_RESET;
    else        c_q <= c_nxt;
  end

  assign flags = c_q;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (set_mask == 8'h00)) |=> (c_q == 8'h00)); // R10
endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl
  import rtcu_pkg::*;
#(
  parameter int UPD_TICKS = 32440
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_en,
  input  logic       sec_tick,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hr,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hr,
  output logic       adv_time,
  output logic       publish,
  output logic       reload,
  output logic       irq
);
  logic       rst_sync_n;
  logic [7:0] reg_a, reg_b, reg_c;
  logic       start, done, busy, alarm_hit;
  logic       osc_ok, set_mode;
  logic [7:0] set_mask;
  logic       wr_a, wr_b, rd_c;

  rtcu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_a     = reg_wr && (reg_sel == SEL_A);
  assign wr_b     = reg_wr && (reg_sel == SEL_B);
  assign rd_c     = reg_rd && (reg_sel == SEL_C);
  assign osc_ok   = (reg_a[6:4] == OSC_RUN);
  assign set_mode = reg_b[BIT_SET];

  rtcu_ctrl_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_a         (wr_a),
    .wr_b         (wr_b),
    .wdata        (reg_wdata),
    .uip_set      (start && !set_mode),
    .uip_done_clr (done),
    .reg_a        (reg_a),
    .reg_b        (reg_b),
    .reload       (reload)
  );

  rtcu_update_seq #(.UPD_TICKS(UPD_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tb_en    (tb_en),
    .sec_tick (sec_tick),
    .osc_ok   (osc_ok),
    .start    (start),
    .done     (done),
    .busy     (busy)
  );

  rtcu_alarm_cmp #(.NUM_FIELDS(3), .FW(8)) u_alarm (
    .alarm_bytes ({alm_hr, alm_min, alm_sec}),
    .now_bytes   ({cur_hr, cur_min, cur_sec}),
    .hit         (alarm_hit)
  );

  always_comb begin
    set_mask = 8'h00;
    if (done) begin
      if (reg_b[BIT_AIE] && alarm_hit) set_mask = set_mask | FLAG_ALM;
      if (reg_b[BIT_UIE])              set_mask = set_mask | FLAG_UPD;
    end
  end

  rtcu_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_mask (set_mask),
    .rd_clr   (rd_c),
    .flags    (reg_c)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_A:   reg_rdata = reg_a;
      SEL_B:   reg_rdata = reg_b;
      SEL_C:   reg_rdata = reg_c;
      default: reg_rdata = D_VALUE;
    endcase
  end

  assign adv_time = start;
  assign publish  = done && !set_mode;
  assign irq      = reg_c[7];

  AST_UIP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_a[BIT_UIP] |-> busy); // R3

  AST_IRQ_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> $past(done)); // R9
endmodule

// File: tb/rtc_update_ctrl_tb.sv
module rtc_update_ctrl_tb;
  localparam int TICKS = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
  logic [7:0] cur_sec = 8'h01, cur_min = 8'h00, cur_hr = 8'h00;
  logic       adv_time, publish, reload, irq;
  logic       slow_mode = 1'b0;
  int         tb_div = 0;
  logic       tb_en;
  int         n_checks = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) tb_div <= (tb_div == 2) ? 0 : tb_div + 1;
  assign tb_en = slow_mode ? (tb_div == 0) : 1'b1;

  rtc_update_ctrl #(.UPD_TICKS(TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .sec_tick(sec_tick),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .adv_time(adv_time), .publish(publish), .reload(reload), .irq(irq)
  );

  // sec, min, hr alarm; sec, min, hr current; expected alarm
  localparam logic [48:0] VEC [7] = '{
    {8'h30, 8'h15, 8'h08, 8'h30, 8'h15, 8'h08, 1'b1},
    {8'hC0, 8'hC0, 8'hC0, 8'h12, 8'h34, 8'h56, 1'b1},
    {8'h30, 8'h15, 8'h08, 8'h31, 8'h15, 8'h08, 1'b0},
    {8'hC5, 8'h15, 8'h08, 8'h59, 8'h15, 8'h08, 1'b1},
    {8'h30, 8'hFF, 8'h08, 8'h30, 8'h15, 8'h08, 1'b1},
    {8'h80, 8'h15, 8'h08, 8'h00, 8'h15, 8'h08, 1'b0},
    {8'h30, 8'h15, 8'h48, 8'h30, 8'h15, 8'h08, 1'b0}
  };

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d, output logic rl);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    #1 rl = reload;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic run_update(output logic adv, output logic pub,
                            output int ttp, output logic uip_seen);
    int n;
    n = 0; pub = 1'b0; ttp = -1; uip_seen = 1'b0;
    @(negedge clk);
    reg_sel = 2'd0; sec_tick = 1'b1;
    #1 adv = adv_time;
    @(negedge clk);
    sec_tick = 1'b0;
    repeat (TICKS * 4 + 6) begin
      #1;
      if (tb_en) n++;
      if (publish && !pub) begin pub = 1'b1; ttp = n; end
      if (reg_rdata[7]) uip_seen = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got 0x1 expected 0x0");
    finish_up();
  end

  initial begin
    logic [7:0] d;
    logic rl, adv, pub, uip;
    int ttp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd_reg(2'd0, d); check("R1 A", d, 8'h26);
    rd_reg(2'd1, d); check("R1 B", d, 8'h00);
    rd_reg(2'd2, d); check("R1 C", d, 8'h00);
    rd_reg(2'd3, d); check("R1 D", d, 8'h80);
    check("R1 irq", irq, 0);

    // R8 alarm vector table (AIE set, UIE clear)
    wr_reg(2'd1, 8'h22, rl);
    foreach (VEC[i]) begin
      {alm_sec, alm_min, alm_hr, cur_sec, cur_min, cur_hr} = VEC[i][48:1];
      run_update(adv, pub, ttp, uip);
      rd_reg(2'd2, d);
      check($sformatf("R8 alarm vector %0d", i), d, VEC[i][0] ? 8'hA0 : 8'h00);
    end
    rd_reg(2'd2, d); check("R10 C empty after read", d, 8'h00);

    // R8 AIE clear: matching bytes raise nothing
    wr_reg(2'd1, 8'h02, rl);
    {alm_sec, alm_min, alm_hr, cur_sec, cur_min, cur_hr} = {8'hC0, 8'hC0, 8'hC0, 8'h00, 8'h00, 8'h00};
    run_update(adv, pub, ttp, uip);
    rd_reg(2'd2, d); check("R8 AIE off no flag", d, 8'h00);

    // R2 R3 R4 normal update
    check("R2 adv_time at start", adv, 1);
    check("R3 UIP seen during update", uip, 1);
    check("R4 publish seen", pub, 1);
    check("R4 ticks to publish", ttp, TICKS);
    rd_reg(2'd0, d); check("R3 UIP cleared at completion", d[7], 0);

    // R4 slower time base
    slow_mode = 1'b1;
    run_update(adv, pub, ttp, uip);
    check("R4 ticks to publish slow base", ttp, TICKS);
    slow_mode = 1'b0;

    // R2 oscillator field not 010: tick ignored
    wr_reg(2'd0, 8'h46, rl);
    run_update(adv, pub, ttp, uip);
    check("R2 blocked adv_time", adv, 0);
    check("R2 blocked publish", pub, 0);
    check("R2 blocked UIP", uip, 0);
    wr_reg(2'd0, 8'h26, rl);

    // R5 A[7] read-only at idle
    wr_reg(2'd0, 8'hA6, rl);
    rd_reg(2'd0, d); check("R5 write 1 to A7 at idle", d, 8'h26);

    // R5 and R6 during an update
    @(negedge clk); reg_sel = 2'd0; sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    wr_reg(2'd0, 8'h26, rl);
    rd_reg(2'd0, d); check("R5 A7 kept over write", d, 8'hA6);
    wr_reg(2'd1, 8'h80, rl);
    rd_reg(2'd0, d); check("R6 SET write clears UIP", d, 8'h26);
    repeat (TICKS + 4) @(negedge clk);

    // R6 UIE forced low
    wr_reg(2'd1, 8'h90, rl);
    rd_reg(2'd1, d); check("R6 UIE forced low", d, 8'h80);

    // R3 R4 under SET: advance, no UIP, no publish
    run_update(adv, pub, ttp, uip);
    check("R2 adv under SET", adv, 1);
    check("R3 no UIP under SET", uip, 0);
    check("R4 no publish under SET", pub, 0);

    // R7 reload
    wr_reg(2'd1, 8'h00, rl); check("R7 reload on SET fall", rl, 1);
    wr_reg(2'd1, 8'h00, rl); check("R7 no reload when SET stays low", rl, 0);

    // R9 update-ended flag and irq, R10 read clears
    wr_reg(2'd1, 8'h10, rl);
    run_update(adv, pub, ttp, uip);
    check("R9 irq after update", irq, 1);
    rd_reg(2'd2, d); check("R9 C update flag", d, 8'h90);
    #1 check("R10 irq low after read", irq, 0);

    // R10 flag set in the same cycle as the read is kept
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    for (int k = 0; k < TICKS * 2; k++) begin
      #1;
      if (publish) break;
      @(negedge clk);
    end
    reg_sel = 2'd2; reg_rd = 1'b1;
    #1 check("R10 old C during read", reg_rdata, 8'h00);
    @(negedge clk); reg_rd = 1'b0;
    rd_reg(2'd2, d); check("R10 flag kept over read", d, 8'h90);

    finish_up();
  end
endmodule